// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit forms the byte address for 32-bit load and store operations and prepares loaded sub-word data for the register file. A request carries an already decoded addressing form, a 16-bit displacement, the base and index register values, a flag that marks the base field as naming register zero, and the access size. One cycle later the unit answers with the effective address and three decisions. It says whether memory may be accessed, whether the base register must be rewritten with the address, and whether the request is faulty because it is misaligned or uses an illegal encoding.

A separate, independent path takes the 32-bit word returned by memory, the low address bits and the size. One cycle later it returns the addressed byte or halfword, placed at the low end of a 32-bit result and extended with zeros or with its sign bit. Byte lanes follow big-endian order, so the lowest address is the most significant byte of the word. The memory array, register file and instruction decode sit outside this block.

Top module: `lsea_unit`

## Requirements
- R1: In the displacement forms (`req_form` 0 and 2), the effective address is the base term plus the 16-bit displacement sign-extended to 32 bits. The sum wraps modulo 2^32.
- R2: When `req_base_is_r0` is high, the base term is zero whatever value `req_base` carries. This holds in every form.
- R3: In the indexed forms (`req_form` 1 and 3), the effective address is the base term plus `req_index`, modulo 2^32.
- R4: Update forms (`req_form` 2 and 3) raise `rsp_wb_en` when they are aligned and legal. The value to write back is `rsp_ea`. Forms 0 and 1 never raise `rsp_wb_en`.
- R5: `req_size` encodes 0 as byte, 1 as halfword, and 2 or 3 as word. A halfword at an odd address, or a word at an address that is not a multiple of 4, raises `rsp_misalign`. It also holds `rsp_mem_en` and `rsp_wb_en` low. Byte accesses are never misaligned.
- R6: An update form with `req_base_is_r0` high raises `rsp_illegal`. It holds `rsp_wb_en` and `rsp_mem_en` low.
- R7: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_mem_en`, `rsp_wb_en`, `rsp_misalign` and `rsp_illegal` are low. After reset, every output is zero.
- R8: For a byte (`fmt_size` 0), offset k selects bits [31-8k : 24-8k] of `fmt_word`. The byte is zero-extended when `fmt_signed` is low and sign-extended when it is high.
- R9: For a halfword (`fmt_size` 1), `fmt_offs[1]` = 0 selects bits [31:16] and 1 selects bits [15:0]. `fmt_offs[0]` is ignored. Extension follows `fmt_signed` as in R8.
- R10: For a word (`fmt_size` 2 or 3), `fmt_word` passes unchanged. `fmt_rvalid` is high exactly in the cycle after `fmt_valid`, with `fmt_data` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Address request present |
| req_form | input | 2 | 0 disp, 1 indexed, 2 disp+update, 3 indexed+update |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_disp | input | 16 | Signed displacement |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_base_is_r0 | input | 1 | Base field names register zero |
| rsp_valid | output | 1 | Response present |
| rsp_ea | output | 32 | Effective address, also the write-back value |
| rsp_mem_en | output | 1 | Memory access allowed |
| rsp_wb_en | output | 1 | Write `rsp_ea` into the base register |
| rsp_misalign | output | 1 | Alignment fault |
| rsp_illegal | output | 1 | Update form with a register-zero base |
| fmt_valid | input | 1 | Load data present |
| fmt_word | input | 32 | Word read from memory |
| fmt_offs | input | 2 | Low address bits of the access |
| fmt_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| fmt_signed | input | 1 | Sign-extend instead of zero-extend |
| fmt_rvalid | output | 1 | Formatted data present |
| fmt_data | output | 32 | Extended load result |

## Verification
The clocked properties assume that every input is at a known level from reset onward. They also assume that the request and load-format fields are sampled only in cycles where their valid is high. The bench keeps to this by driving all inputs to defined values before reset is released and by changing them only on the falling clock edge. Random requests draw form and size from their full 2-bit ranges, so the reserved word encoding 3 is also covered. The base and index operands include values that wrap past 2^32.

// File: rtl/lsea_pkg.sv
package lsea_pkg;
  typedef enum logic [1:0] {
    FORM_DISP      = 2'd0,
    FORM_INDEX     = 2'd1,
    FORM_DISP_UPD  = 2'd2,
    FORM_INDEX_UPD = 2'd3
  } ea_form_e;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_HALF     = 2'd1,
    SZ_WORD     = 2'd2,
    SZ_WORD_ALT = 2'd3
  } acc_size_e;

  function automatic logic form_indexed(input ea_form_e f);
    return (f == FORM_INDEX) || (f == FORM_INDEX_UPD);
  endfunction

  function automatic logic form_update(input ea_form_e f);
    return (f == FORM_DISP_UPD) || (f == FORM_INDEX_UPD);
  endfunction
endpackage

// File: rtl/lsea_agen.sv
module lsea_agen
  import lsea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic [1:0]        form,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic              base_is_r0,
  output logic [ADDR_W-1:0] ea
);
  localparam int EXT_W = ADDR_W - DISP_W;

  function automatic logic [ADDR_W-1:0] widen_disp(input logic [DISP_W-1:0] d);
    return {{EXT_W{d[DISP_W-1]}}, d};
  endfunction

  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] add_term;

  assign base_term = base_is_r0 ? '0 : base;
  assign add_term  = form_indexed(ea_form_e'(form)) ? index : widen_disp(disp);
  assign ea        = base_term + add_term;
endmodule

// File: rtl/lsea_check.sv
module lsea_check
  import lsea_pkg::*;
(
  input  logic [1:0] form,
  input  logic [1:0] size,
  input  logic [1:0] ea_lo,
  input  logic       base_is_r0,
  output logic       misalign,
  output logic       illegal,
  output logic       mem_en,
  output logic       wb_en
);
  function automatic logic off_grid(input acc_size_e sz, input logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_HALF: return lo[0];
      default: return |lo;
    endcase
  endfunction

  logic is_upd;
  assign is_upd   = form_update(ea_form_e'(form));
  assign misalign = off_grid(acc_size_e'(size), ea_lo);
  assign illegal  = is_upd & base_is_r0;
  assign mem_en   = ~misalign & ~illegal;
  assign wb_en    = is_upd & mem_en;
endmodule

// File: rtl/lsea_ldfmt.sv
module lsea_ldfmt
  import lsea_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]                 word,
  input  logic [$clog2(DATA_W/8)-1:0]       offs,
  input  logic [1:0]                        size,
  input  logic                              sgn,
  output logic [DATA_W-1:0]                 data
);
  localparam int NBYTE = DATA_W / 8;
  localparam int NHALF = DATA_W / 16;
  localparam int OFF_W = $clog2(NBYTE);

  logic [7:0]  byte_lane [NBYTE];
  logic [15:0] half_lane [NHALF];

  for (genvar b = 0; b < NBYTE; b++) begin : g_byte
    assign byte_lane[b] = word[DATA_W-1-8*b -: 8];
  end
  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign half_lane[h] = word[DATA_W-1-16*h -: 16];
  end

  function automatic logic [DATA_W-1:0] ext8(input logic [7:0] v, input logic s);
    return {{(DATA_W-8){s & v[7]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] ext16(input logic [15:0] v, input logic s);
    return {{(DATA_W-16){s & v[15]}}, v};
  endfunction

  logic [7:0]  sel_byte;
  logic [15:0] sel_half;
  assign sel_byte = byte_lane[offs];
  assign sel_half = half_lane[offs[OFF_W-1:1]];

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: data = ext8(sel_byte, sgn);
      SZ_HALF: data = ext16(sel_half, sgn);
      default: data = word;
    endcase
  end
endmodule

// File: rtl/lsea_unit.sv
module lsea_unit
  import lsea_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [1:0]                  req_form,
  input  logic [1:0]                  req_size,
  input  logic [DISP_W-1:0]           req_disp,
  input  logic [ADDR_W-1:0]           req_base,
  input  logic [ADDR_W-1:0]           req_index,
  input  logic                        req_base_is_r0,
  output logic                        rsp_valid,
  output logic [ADDR_W-1:0]           rsp_ea,
  output logic                        rsp_mem_en,
  output logic                        rsp_wb_en,
  output logic                        rsp_misalign,
  output logic                        rsp_illegal,
  input  logic                        fmt_valid,
  input  logic [DATA_W-1:0]           fmt_word,
  input  logic [$clog2(DATA_W/8)-1:0] fmt_offs,
  input  logic [1:0]                  fmt_size,
  input  logic                        fmt_signed,
  output logic                        fmt_rvalid,
  output logic [DATA_W-1:0]           fmt_data
);
  logic [ADDR_W-1:0] ea_c;
  logic              mis_c, ill_c, mem_c, wb_c;
  logic [DATA_W-1:0] fmt_c;

  lsea_agen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_agen (
    .form(req_form), .disp(req_disp), .base(req_base), .index(req_index),
    .base_is_r0(req_base_is_r0), .ea(ea_c)
  );

  lsea_check u_check (
    .form(req_form), .size(req_size), .ea_lo(ea_c[1:0]),
    .base_is_r0(req_base_is_r0), .misalign(mis_c), .illegal(ill_c),
    .mem_en(mem_c), .wb_en(wb_c)
  );

  lsea_ldfmt #(.DATA_W(DATA_W)) u_fmt (
    .word(fmt_word), .offs(fmt_offs), .size(fmt_size), .sgn(fmt_signed),
    .data(fmt_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_ea       <= '0;
      rsp_mem_en   <= 1'b0;
      rsp_wb_en    <= 1'b0;
      rsp_misalign <= 1'b0;
      rsp_illegal  <= 1'b0;
      fmt_rvalid   <= 1'b0;
      fmt_data     <= '0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_mem_en   <= req_valid & mem_c;
      rsp_wb_en    <= req_valid & wb_c;
      rsp_misalign <= req_valid & mis_c;
      rsp_illegal  <= req_valid & ill_c;
      if (req_valid) rsp_ea <= ea_c;
      fmt_rvalid   <= fmt_valid;
      if (fmt_valid) fmt_data <= fmt_c;
    end
  end

  // R7: response timing follows the request strobe
  a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r7_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_mem_en && !rsp_wb_en && !rsp_misalign && !rsp_illegal);
  // R5: an alignment fault blocks memory and write-back
  a_r5_misalign_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_misalign |-> !rsp_mem_en && !rsp_wb_en);
  // R6: an illegal update never writes back
  a_r6_illegal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> !rsp_wb_en && !rsp_mem_en);
  // R4: only update forms write back
  a_r4_wb_only_update: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_form[1] |=> !rsp_wb_en);
  // R2: a register-zero base in displacement form yields the bare displacement
  a_r2_zero_base: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_base_is_r0 && !req_form[0] |=>
      rsp_ea == {{(ADDR_W-DISP_W){$past(req_disp[DISP_W-1])}}, $past(req_disp)});
  // R8: an unsigned byte load leaves the upper bits clear
  a_r8_byte_zext: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_valid && !fmt_signed && fmt_size == 2'd0 |=> fmt_data[DATA_W-1:8] == '0);
  // R10: formatted data strobe follows its input strobe
  a_r10_fmt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_valid |=> fmt_rvalid);
endmodule

// File: tb/lsea_unit_test.sv
module lsea_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_form = '0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_disp = '0;
  logic [31:0] req_base = '0;
  logic [31:0] req_index = '0;
  logic        req_base_is_r0 = 1'b0;
  logic        rsp_valid, rsp_mem_en, rsp_wb_en, rsp_misalign, rsp_illegal;
  logic [31:0] rsp_ea;
  logic        fmt_valid = 1'b0;
  logic [31:0] fmt_word = '0;
  logic [1:0]  fmt_offs = '0;
  logic [1:0]  fmt_size = '0;
  logic        fmt_signed = 1'b0;
  logic        fmt_rvalid;
  logic [31:0] fmt_data;

  always #4 clk = ~clk;

  lsea_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_form(req_form),
    .req_size(req_size), .req_disp(req_disp), .req_base(req_base),
    .req_index(req_index), .req_base_is_r0(req_base_is_r0),
    .rsp_valid(rsp_valid), .rsp_ea(rsp_ea), .rsp_mem_en(rsp_mem_en),
    .rsp_wb_en(rsp_wb_en), .rsp_misalign(rsp_misalign), .rsp_illegal(rsp_illegal),
    .fmt_valid(fmt_valid), .fmt_word(fmt_word), .fmt_offs(fmt_offs),
    .fmt_size(fmt_size), .fmt_signed(fmt_signed), .fmt_rvalid(fmt_rvalid),
    .fmt_data(fmt_data)
  );

  typedef struct {
    string       tag;
    logic [31:0] ea;
    logic        mem, wb, mis, ill;
  } rsp_item_t;

  typedef struct {
    string       tag;
    logic [31:0] data;
  } fmt_item_t;

  rsp_item_t rq[$];
  fmt_item_t fq[$];
  int checks = 0;
  int errors = 0;
  bit reported = 0;

  task automatic check(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: computes the expected response and pushes it to the scoreboard
  task automatic send_req(input string tag, input logic [1:0] form, input logic [1:0] size,
                          input logic [15:0] disp, input logic [31:0] base,
                          input logic [31:0] index, input logic r0);
    rsp_item_t it;
    logic [31:0] b, off;
    bit upd, idx;
    upd = (form == 2'd2) || (form == 2'd3);
    idx = (form == 2'd1) || (form == 2'd3);
    b   = r0 ? 32'd0 : base;
    off = idx ? index : 32'($signed(disp));
    it.tag = tag;
    it.ea  = b + off;
    it.mis = (size == 2'd1) ? (it.ea % 2 != 0) : (size >= 2'd2) ? (it.ea % 4 != 0) : 1'b0;
    it.ill = upd && r0;
    it.mem = !it.mis && !it.ill;
    it.wb  = upd && it.mem;
    rq.push_back(it);
    req_valid = 1'b1; req_form = form; req_size = size; req_disp = disp;
    req_base = base; req_index = index; req_base_is_r0 = r0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic send_fmt(input string tag, input logic [31:0] w, input logic [1:0] offs,
                          input logic [1:0] size, input logic sgn);
    fmt_item_t it;
    logic [31:0] v;
    it.tag = tag;
    if (size == 2'd0) begin
      v = (w << (8 * offs)) >> 24;
      if (sgn && v[7]) v = v | 32'hFFFF_FF00;
    end else if (size == 2'd1) begin
      v = (w >> (offs >= 2'd2 ? 0 : 16)) & 32'h0000_FFFF;
      if (sgn && v[15]) v = v | 32'hFFFF_0000;
    end else begin
      v = w;
    end
    it.data = v;
    fq.push_back(it);
    fmt_valid = 1'b1; fmt_word = w; fmt_offs = offs; fmt_size = size; fmt_signed = sgn;
    @(negedge clk);
    fmt_valid = 1'b0;
  endtask

  // Monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (rq.size() == 0) begin
          check("R7", "unexpected rsp_valid", 32'd1, 32'd0);
        end else begin
          rsp_item_t e;
          e = rq.pop_front();
          check(e.tag, "rsp_ea", rsp_ea, e.ea);
          check("R5", "rsp_misalign", {31'd0, rsp_misalign}, {31'd0, e.mis});
          check("R6", "rsp_illegal", {31'd0, rsp_illegal}, {31'd0, e.ill});
          check("R5", "rsp_mem_en", {31'd0, rsp_mem_en}, {31'd0, e.mem});
          check("R4", "rsp_wb_en", {31'd0, rsp_wb_en}, {31'd0, e.wb});
        end
      end else begin
        check("R7", "idle flags", {28'd0, rsp_mem_en, rsp_wb_en, rsp_misalign, rsp_illegal}, 32'd0);
      end
      if (fmt_rvalid) begin
        if (fq.size() == 0) begin
          check("R10", "unexpected fmt_rvalid", 32'd1, 32'd0);
        end else begin
          fmt_item_t f;
          f = fq.pop_front();
          check(f.tag, "fmt_data", fmt_data, f.data);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R7", "reset rsp_ea", rsp_ea, 32'd0);
    check("R7", "reset fmt_data", fmt_data, 32'd0);
    check("R7", "reset fmt_rvalid", {31'd0, fmt_rvalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 displacement forms
    send_req("R1", 2'd0, 2'd2, 16'h0010, 32'h0000_1000, 32'hDEAD_BEEF, 1'b0);
    send_req("R1", 2'd0, 2'd2, 16'hFFF0, 32'h0000_1000, 32'h0, 1'b0);
    send_req("R1", 2'd0, 2'd0, 16'h0002, 32'hFFFF_FFFE, 32'h0, 1'b0);
    // R2 register-zero base
    send_req("R2", 2'd0, 2'd1, 16'h8000, 32'h1234_5678, 32'h0, 1'b1);
    send_req("R2", 2'd1, 2'd2, 16'h0, 32'hFFFF_0000, 32'h0000_0040, 1'b1);
    // R3 indexed
    send_req("R3", 2'd1, 2'd2, 16'h7FFF, 32'h0000_0300, 32'h0000_0008, 1'b0);
    send_req("R3", 2'd1, 2'd1, 16'h0, 32'h8000_0000, 32'h8000_0002, 1'b0);
    // R4 update forms
    send_req("R4", 2'd2, 2'd2, 16'h0004, 32'h0000_2000, 32'h0, 1'b0);
    send_req("R4", 2'd3, 2'd3, 16'h0, 32'h0000_2000, 32'h0000_0010, 1'b0);
    // R5 misalignment
    send_req("R5", 2'd0, 2'd1, 16'h0001, 32'h0000_1000, 32'h0, 1'b0);
    send_req("R5", 2'd0, 2'd2, 16'h0002, 32'h0000_1000, 32'h0, 1'b0);
    send_req("R5", 2'd2, 2'd2, 16'h0001, 32'h0000_1000, 32'h0, 1'b0);
    send_req("R5", 2'd0, 2'd0, 16'h0003, 32'h0000_1000, 32'h0, 1'b0);
    // R6 illegal update with zero base
    send_req("R6", 2'd2, 2'd2, 16'h0008, 32'h0000_1000, 32'h0, 1'b1);
    send_req("R6", 2'd3, 2'd0, 16'h0, 32'h0000_1000, 32'h0000_0005, 1'b1);
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      logic [31:0] rb;
      rb = $urandom;
      send_req((i % 2 == 0) ? "R1" : "R3", 2'($urandom), 2'($urandom), 16'($urandom),
               rb, 32'($urandom), 1'($urandom % 4 == 0));
    end
    @(negedge clk);

    // R8 byte lanes
    for (int k = 0; k < 4; k++) begin
      send_fmt("R8", 32'h80F1_7F02, 2'(k), 2'd0, 1'b0);
      send_fmt("R8", 32'h80F1_7F02, 2'(k), 2'd0, 1'b1);
    end
    // R9 halfword lanes; low offset bit ignored
    send_fmt("R9", 32'h8001_7FFE, 2'd0, 2'd1, 1'b1);
    send_fmt("R9", 32'h8001_7FFE, 2'd1, 2'd1, 1'b0);
    send_fmt("R9", 32'h8001_F00D, 2'd2, 2'd1, 1'b1);
    send_fmt("R9", 32'h8001_F00D, 2'd3, 2'd1, 1'b0);
    // R10 word pass-through
    send_fmt("R10", 32'hCAFE_F00D, 2'd0, 2'd2, 1'b1);
    send_fmt("R10", 32'h8000_0001, 2'd2, 2'd3, 1'b1);
    repeat (3) @(negedge clk);
    check("R7", "leftover responses", 32'(rq.size()), 32'd0);
    check("R10", "leftover load data", 32'(fq.size()), 32'd0);
    report();
  end
endmodule